// File: doc/BRIEF.md
# Atomic Memory Operation Unit

This block sits in front of a small word-addressed memory and performs indivisible read-modify-write operations for several requesters. Each requester has its own request port carrying an operation code, a word address and a write value. A rotating-priority arbiter picks at most one request per cycle. The picked operation reads the word, computes the result and writes it back in the same cycle, so no other access can fall between the read and the write.

The operations are exchange, test-and-set, fetch-and-increment, load-linked, store-conditional and a side-effect-free peek. Each requester owns one link reservation, which holds a valid bit and an address. A store-conditional writes only while its reservation still names the target address. A write to an address by any requester removes every reservation on that address. Lock code uses the convention that zero means free.

A requester holds its request until it sees its grant bit. One cycle after the grant, the result appears on a shared response port, tagged with the requester index.

Top module: `amo_unit`

## Requirements
- R1: While reset is low, `rsp_valid` is 0. After reset, every memory word reads 0 and no requester holds a reservation.
- R2: Exchange (op code 0) returns the old word with `rsp_ok`=1 and writes the request value.
- R3: Test-and-set (op code 1) returns the old word. When the old word is 0 it writes 1 and gives `rsp_ok`=1. Otherwise it leaves the word unchanged and gives `rsp_ok`=0.
- R4: Fetch-and-increment (op code 2) returns the old word with `rsp_ok`=1 and writes the old word plus one, wrapping modulo 2^DATA_W.
- R5: Load-linked (op code 3) returns the word with `rsp_ok`=1 and records a reservation on that address for the requester. It does not write memory.
- R6: Store-conditional (op code 4) returns the current word. If the requester holds a reservation on that address, it writes the request value and gives `rsp_ok`=1. Otherwise it gives `rsp_ok`=0 and does not write. In both cases it clears the requester's own reservation.
- R7: Any write to an address, by any requester and any operation, clears every reservation on that address. A test-and-set that does not write leaves reservations in place.
- R8: A load-linked to a new address replaces the requester's earlier reservation, so a later store-conditional to the old address fails.
- R9: At most one request is granted per cycle, and only a valid one. Its response appears on the next cycle with `rsp_valid`=1 and `rsp_id` equal to the granted index. With no grant, `rsp_valid` is 0 on the next cycle.
- R10: Priority rotates. The search starts just after the last granted requester, so the last one granted is served last while others wait. After reset, requester 0 ranks first.
- R11: Op codes 5 to 7 return the word with `rsp_ok`=0. They write nothing and leave all reservations unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NUM_REQ | Request pending, one bit per requester, held until granted |
| req_op | input | NUM_REQ x 3 | Operation code per requester |
| req_addr | input | NUM_REQ x ADDR_W | Word address per requester |
| req_wdata | input | NUM_REQ x DATA_W | Write or exchange value per requester |
| req_grant | output | NUM_REQ | One-hot grant for this cycle |
| rsp_valid | output | 1 | Response strobe, one cycle after a grant |
| rsp_id | output | clog2(NUM_REQ) | Index of the requester being answered |
| rsp_data | output | DATA_W | Word value read by the operation |
| rsp_ok | output | 1 | Success flag as defined per operation |

## Verification
Two pairs of functions can collide in one cycle. The first is two test-and-set requests racing for the same free lock. The second is a store-conditional from one requester arriving in the same cycle as an exchange by another requester to the linked address. The bench raises both requests on the same edge directly after a reset, so the rotation order is known. It then judges the outcome by which requester receives the 0 and `rsp_ok`=1, by whether the store-conditional fails, and by the word a later peek returns. A four-way fetch-and-increment burst also checks the grant order and the serialized values 0 to 3.

// File: rtl/amo_pkg.sv
// Package: shared operation codes for the atomic memory unit.
// Assumes a 3-bit operation field; codes 5..7 behave as a peek.
package amo_pkg;
    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        AMO_SWAP = 3'd0,
        AMO_TAS  = 3'd1,
        AMO_FINC = 3'd2,
        AMO_LL   = 3'd3,
        AMO_SC   = 3'd4,
        AMO_PEEK = 3'd5
    } amo_op_e;
endpackage

// File: rtl/amo_rr_arbiter.sv
// Rotating-priority arbiter: grants at most one valid requester per cycle,
// starting the search just after the last winner.
// Assumes requesters hold req until granted; NUM_REQ >= 2.
module amo_rr_arbiter #(
    parameter int NUM_REQ = 4,
    parameter int ID_W    = $clog2(NUM_REQ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] req,
    output logic [NUM_REQ-1:0] grant,
    output logic [ID_W-1:0]    grant_idx,
    output logic               grant_any
);
    logic [ID_W-1:0] last_q;
    logic            armed_q;

    function automatic logic [ID_W-1:0] wrap_idx(input int v);
        return ID_W'(v % NUM_REQ);
    endfunction

    // Search the requesters in rotated order and pick the first pending one.
    always_comb begin
        grant     = '0;
        grant_idx = '0;
        grant_any = 1'b0;
        for (int k = 1; k <= NUM_REQ; k++) begin
            if (!grant_any && req[wrap_idx(int'(last_q) + k)]) begin
                grant_any                          = 1'b1;
                grant_idx                          = wrap_idx(int'(last_q) + k);
                grant[wrap_idx(int'(last_q) + k)]  = 1'b1;
            end
        end
    end

    // Remember the last winner; reset makes requester 0 rank first.
    always_ff @(posedge clk) begin
        if (!rst_n)         last_q <= ID_W'(NUM_REQ - 1);
        else if (grant_any) last_q <= grant_idx;
    end

    // Mark the first cycle whose previous cycle was out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    p_one_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    p_grant_has_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);

    p_winner_yields_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(grant_any) && req[$past(grant_idx)] && ($countones(req) > 1))
        |-> !grant[$past(grant_idx)]);
endmodule

// File: rtl/amo_exec.sv
// Operation datapath: from the operation code, the word read and the
// reservation match, forms the write value, write enable and success flag.
// Assumes the caller gates the outputs with the grant.
module amo_exec
    import amo_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] old_word,
    input  logic [DATA_W-1:0] wdata,
    input  logic              resv_hit,
    output logic [DATA_W-1:0] new_word,
    output logic              wr_en,
    output logic              ok,
    output logic              link_set,
    output logic              link_drop
);
    // Decode one operation into its memory and reservation effects.
    always_comb begin
        new_word  = wdata;
        wr_en     = 1'b0;
        ok        = 1'b0;
        link_set  = 1'b0;
        link_drop = 1'b0;
        case (amo_op_e'(op))
            AMO_SWAP: begin
                wr_en = 1'b1;
                ok    = 1'b1;
            end
            AMO_TAS: begin
                new_word = DATA_W'(1);
                wr_en    = (old_word == '0);
                ok       = (old_word == '0);
            end
            AMO_FINC: begin
                new_word = old_word + DATA_W'(1);
                wr_en    = 1'b1;
                ok       = 1'b1;
            end
            AMO_LL: begin
                ok       = 1'b1;
                link_set = 1'b1;
            end
            AMO_SC: begin
                wr_en     = resv_hit;
                ok        = resv_hit;
                link_drop = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/amo_resv.sv
// Link reservation table: one valid bit and address per requester, set by
// load-linked, dropped by the owner's store-conditional or by any write to
// the reserved address. Assumes at most one event per cycle.
module amo_resv #(
    parameter int NUM_REQ = 4,
    parameter int ADDR_W  = 4,
    parameter int ID_W    = $clog2(NUM_REQ)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   who,
    input  logic [ADDR_W-1:0] addr,
    input  logic              set_en,
    input  logic              drop_en,
    input  logic              wr_en,
    output logic              hit
);
    logic [NUM_REQ-1:0]             live_q;
    logic [NUM_REQ-1:0][ADDR_W-1:0] addr_q;

    // The granted requester's reservation matches the current address.
    assign hit = live_q[who] && (addr_q[who] == addr);

    for (genvar i = 0; i < NUM_REQ; i++) begin : g_slot
        // Track one requester's reservation.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                live_q[i] <= 1'b0;
                addr_q[i] <= '0;
            end else if (set_en && who == ID_W'(i)) begin
                live_q[i] <= 1'b1;
                addr_q[i] <= addr;
            end else if ((drop_en && who == ID_W'(i)) ||
                         (wr_en && addr_q[i] == addr)) begin
                live_q[i] <= 1'b0;
            end
        end

        p_own_sc_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (drop_en && who == ID_W'(i)) |=> !live_q[i]);

        p_write_kills_link_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && live_q[i] && addr_q[i] == addr) |=> !live_q[i]);
    end
endmodule

// File: rtl/amo_unit.sv
// Atomic memory unit top: arbitrates requesters, performs one read-modify-
// write per cycle on a flop-array memory and returns a registered response.
// Assumes requesters hold their request until req_grant; NUM_REQ >= 2.
module amo_unit
    import amo_pkg::*;
#(
    parameter int NUM_REQ = 4,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_REQ-1:0]               req_valid,
    input  logic [NUM_REQ-1:0][OP_W-1:0]     req_op,
    input  logic [NUM_REQ-1:0][ADDR_W-1:0]   req_addr,
    input  logic [NUM_REQ-1:0][DATA_W-1:0]   req_wdata,
    output logic [NUM_REQ-1:0]               req_grant,
    output logic                             rsp_valid,
    output logic [$clog2(NUM_REQ)-1:0]       rsp_id,
    output logic [DATA_W-1:0]                rsp_data,
    output logic                             rsp_ok
);
    localparam int ID_W  = $clog2(NUM_REQ);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [ID_W-1:0]   win;
    logic              win_any;
    logic [ADDR_W-1:0] sel_addr;
    logic [DATA_W-1:0] old_word;
    logic [DATA_W-1:0] new_word;
    logic              exe_wr, exe_ok, exe_set, exe_drop, resv_hit;
    logic              wr_go;
    logic [ADDR_W-1:0] last_addr_q;

    amo_rr_arbiter #(.NUM_REQ(NUM_REQ), .ID_W(ID_W)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req_valid),
        .grant     (req_grant),
        .grant_idx (win),
        .grant_any (win_any)
    );

    // Route the winner's address and read the word it names.
    assign sel_addr = req_addr[win];
    assign old_word = mem_q[sel_addr];

    amo_exec #(.DATA_W(DATA_W)) u_exec (
        .op        (req_op[win]),
        .old_word  (old_word),
        .wdata     (req_wdata[win]),
        .resv_hit  (resv_hit),
        .new_word  (new_word),
        .wr_en     (exe_wr),
        .ok        (exe_ok),
        .link_set  (exe_set),
        .link_drop (exe_drop)
    );

    assign wr_go = win_any && exe_wr;

    amo_resv #(.NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W), .ID_W(ID_W)) u_resv (
        .clk     (clk),
        .rst_n   (rst_n),
        .who     (win),
        .addr    (sel_addr),
        .set_en  (win_any && exe_set),
        .drop_en (win_any && exe_drop),
        .wr_en   (wr_go),
        .hit     (resv_hit)
    );

    // Clear the memory on reset; otherwise commit the winner's write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) mem_q[a] <= '0;
        end else if (wr_go) begin
            mem_q[sel_addr] <= new_word;
        end
    end

    // Register the response one cycle after the grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_id      <= '0;
            rsp_data    <= '0;
            rsp_ok      <= 1'b0;
            last_addr_q <= '0;
        end else begin
            rsp_valid   <= win_any;
            rsp_id      <= win;
            rsp_data    <= old_word;
            rsp_ok      <= win_any && exe_ok;
            last_addr_q <= sel_addr;
        end
    end

    p_rsp_follows_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
        win_any |=> (rsp_valid && rsp_id == $past(win)));

    p_idle_no_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !win_any |=> !rsp_valid);

    // A failed operation (TAS on a held lock, failed SC, peek) leaves its word intact.
    p_fail_keeps_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ok) |-> (mem_q[last_addr_q] == rsp_data));
endmodule

// File: tb/amo_unit_test.sv
module amo_unit_test;
    localparam int NR = 4;
    localparam int AW = 4;
    localparam int DW = 16;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [NR-1:0]            req_valid = '0;
    logic [NR-1:0][2:0]       req_op = '0;
    logic [NR-1:0][AW-1:0]    req_addr = '0;
    logic [NR-1:0][DW-1:0]    req_wdata = '0;
    logic [NR-1:0]            req_grant;
    logic                     rsp_valid;
    logic [1:0]               rsp_id;
    logic [DW-1:0]            rsp_data;
    logic                     rsp_ok;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    amo_unit #(.NUM_REQ(NR), .ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_grant(req_grant),
        .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_data(rsp_data), .rsp_ok(rsp_ok)
    );

    always #5 clk = ~clk;

    typedef struct packed {
        logic [3:0]  rq;
        logic [1:0]  id;
        logic [2:0]  op;
        logic [3:0]  addr;
        logic [15:0] wd;
        logic [15:0] ed;
        logic        eok;
    } vec_t;

    // Op codes: 0 exchange, 1 test-and-set, 2 fetch-inc, 3 load-linked, 4 store-cond, 5 peek.
    localparam int NV = 30;
    localparam vec_t VEC [NV] = '{
        '{4'd2,  2'd0, 3'd0, 4'd2,  16'h1234, 16'h0000, 1'b1}, // R2
        '{4'd2,  2'd1, 3'd0, 4'd2,  16'hABCD, 16'h1234, 1'b1}, // R2
        '{4'd11, 2'd2, 3'd5, 4'd2,  16'h0000, 16'hABCD, 1'b0}, // R11
        '{4'd3,  2'd0, 3'd1, 4'd3,  16'h0000, 16'h0000, 1'b1}, // R3 acquire
        '{4'd3,  2'd3, 3'd1, 4'd3,  16'h0000, 16'h0001, 1'b0}, // R3 held
        '{4'd5,  2'd2, 3'd3, 4'd3,  16'h0000, 16'h0001, 1'b1}, // R5
        '{4'd7,  2'd1, 3'd1, 4'd3,  16'h0000, 16'h0001, 1'b0}, // R7 TAS no write
        '{4'd6,  2'd2, 3'd4, 4'd3,  16'h0000, 16'h0001, 1'b1}, // R6 success
        '{4'd6,  2'd2, 3'd4, 4'd3,  16'h0007, 16'h0000, 1'b0}, // R6 reservation used
        '{4'd11, 2'd0, 3'd5, 4'd3,  16'h0000, 16'h0000, 1'b0}, // R11
        '{4'd4,  2'd1, 3'd2, 4'd8,  16'h0000, 16'h0000, 1'b1}, // R4
        '{4'd4,  2'd1, 3'd2, 4'd8,  16'h0000, 16'h0001, 1'b1}, // R4
        '{4'd4,  2'd0, 3'd5, 4'd8,  16'h0000, 16'h0002, 1'b0}, // R4
        '{4'd2,  2'd0, 3'd0, 4'd10, 16'hFFFF, 16'h0000, 1'b1}, // R2
        '{4'd4,  2'd3, 3'd2, 4'd10, 16'h0000, 16'hFFFF, 1'b1}, // R4 wrap
        '{4'd4,  2'd3, 3'd5, 4'd10, 16'h0000, 16'h0000, 1'b0}, // R4 wrap
        '{4'd5,  2'd0, 3'd3, 4'd4,  16'h0000, 16'h0000, 1'b1}, // R5
        '{4'd8,  2'd0, 3'd3, 4'd5,  16'h0000, 16'h0000, 1'b1}, // R8 relink
        '{4'd8,  2'd0, 3'd4, 4'd4,  16'h0011, 16'h0000, 1'b0}, // R8 old address fails
        '{4'd5,  2'd1, 3'd3, 4'd6,  16'h0000, 16'h0000, 1'b1}, // R5
        '{4'd5,  2'd2, 3'd3, 4'd6,  16'h0000, 16'h0000, 1'b1}, // R5
        '{4'd6,  2'd1, 3'd4, 4'd6,  16'h0066, 16'h0000, 1'b1}, // R6
        '{4'd7,  2'd2, 3'd4, 4'd6,  16'h0077, 16'h0066, 1'b0}, // R7 other SC wrote
        '{4'd6,  2'd3, 3'd4, 4'd11, 16'h0009, 16'h0000, 1'b0}, // R6 never linked
        '{4'd6,  2'd3, 3'd5, 4'd6,  16'h0000, 16'h0066, 1'b0}, // R6
        '{4'd5,  2'd0, 3'd3, 4'd12, 16'h0000, 16'h0000, 1'b1}, // R5
        '{4'd7,  2'd1, 3'd2, 4'd12, 16'h0000, 16'h0000, 1'b1}, // R7 fetch-inc writes
        '{4'd7,  2'd0, 3'd4, 4'd12, 16'h0005, 16'h0001, 1'b0}, // R7 SC then fails
        '{4'd11, 2'd2, 3'd7, 4'd12, 16'hFFFF, 16'h0001, 1'b0}, // R11 code 7
        '{4'd11, 2'd2, 3'd5, 4'd12, 16'h0000, 16'h0001, 1'b0}  // R11 nothing written
    };

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic drive(input int id, input logic [2:0] op, input logic [3:0] addr,
                         input logic [15:0] wd);
        req_valid[id] = 1'b1;
        req_op[id]    = op;
        req_addr[id]  = addr;
        req_wdata[id] = wd;
    endtask

    task automatic expect_rsp(input int id, input logic [15:0] ed, input logic eok,
                              input string rq);
        @(negedge clk);
        chk(rq, {31'd0, rsp_valid}, 32'd1);
        chk(rq, {30'd0, rsp_id}, id);
        chk(rq, {16'd0, rsp_data}, {16'd0, ed});
        chk(rq, {31'd0, rsp_ok}, {31'd0, eok});
        req_valid[id] = 1'b0;
    endtask

    task automatic do_reset();
        rst_n     = 1'b0;
        req_valid = '0;
        repeat (3) @(negedge clk);
        chk("R1", {31'd0, rsp_valid}, 32'd0);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        // R1: all words zero, no reservations held.
        for (int a = 0; a < 16; a++) begin
            drive(0, 3'd5, a[3:0], 16'h0);
            expect_rsp(0, 16'h0, 1'b0, "R1");
        end
        for (int r = 0; r < NR; r++) begin
            drive(r, 3'd4, 4'd0, 16'h00AA);
            expect_rsp(r, 16'h0, 1'b0, "R1");
        end
        // Vector table, one requester at a time.
        for (int v = 0; v < NV; v++) begin
            drive(VEC[v].id, VEC[v].op, VEC[v].addr, VEC[v].wd);
            expect_rsp(VEC[v].id, VEC[v].ed, VEC[v].eok, $sformatf("R%0d", VEC[v].rq));
        end
        @(negedge clk);
        chk("R9", {31'd0, rsp_valid}, 32'd0);

        // Contention after a fresh reset: rotation starts at requester 0.
        do_reset();
        drive(1, 3'd1, 4'd3, 16'h0);
        drive(2, 3'd1, 4'd3, 16'h0);
        #1 chk("R10", {28'd0, req_grant}, 32'b0010);
        expect_rsp(1, 16'h0, 1'b1, "R3");
        expect_rsp(2, 16'h1, 1'b0, "R3");
        drive(0, 3'd3, 4'd7, 16'h0);
        expect_rsp(0, 16'h0, 1'b1, "R5");
        // SC by 0 and exchange by 3 in the same cycle; 3 ranks first.
        drive(0, 3'd4, 4'd7, 16'h0055);
        drive(3, 3'd0, 4'd7, 16'h0022);
        #1 chk("R9", {28'd0, req_grant}, 32'b1000);
        expect_rsp(3, 16'h0, 1'b1, "R2");
        expect_rsp(0, 16'h0022, 1'b0, "R7");
        drive(1, 3'd5, 4'd7, 16'h0);
        expect_rsp(1, 16'h0022, 1'b0, "R7");
        // Four-way fetch-inc burst: last winner 1, so order 2,3,0,1.
        for (int r = 0; r < NR; r++) drive(r, 3'd2, 4'd9, 16'h0);
        expect_rsp(2, 16'h0, 1'b1, "R10");
        expect_rsp(3, 16'h1, 1'b1, "R10");
        expect_rsp(0, 16'h2, 1'b1, "R10");
        expect_rsp(1, 16'h3, 1'b1, "R10");
        @(negedge clk);
        chk("R9", {31'd0, rsp_valid}, 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule